// File: doc/BRIEF.md
# Packed Saturating Integer Adder-Subtractor

This block adds or subtracts two 64-bit operands that are each viewed as a vector of equal-width integer lanes. The element size can be 8, 16, 32 or 64 bits. Every lane is computed on its own, and no carry or borrow crosses from one lane into the next. The result is captured in an output register, so it appears one clock after the operands.

Three arithmetic behaviours are offered:

- **Wrap-around.** Plain two's-complement arithmetic modulo 2^n.
- **Signed clamping.** Each lane is limited to -2^(n-1) .. 2^(n-1)-1. The direction of the limit follows the sign of the exact result.
- **Unsigned clamping.** Each lane is limited to 0 .. 2^n-1.

Clamping is available only for 8-bit and 16-bit lanes. When a wider element is selected together with a clamping mode, the lanes wrap. A clamped value is an ordinary number and can be used again in later operations.

Top module: `packed_sat_addsub`

## Requirements
- R1: While `rstN` is low, `result` is 0.
- R2: `result` shows the outcome of the operands and controls that were present at the previous rising clock edge. It changes only on a rising edge.
- R3: `elemSize` selects the lane width: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 64 bits. Lane k occupies bits k*n .. k*n+n-1. No carry or borrow passes between lanes.
- R4: `satMode` selects the arithmetic: 00 = wrap-around, 01 = signed clamping, 10 = unsigned clamping, 11 = wrap-around. In wrap-around mode each lane is the exact result modulo 2^n.
- R5: `isSub` = 0 computes opA + opB per lane. `isSub` = 1 computes opA - opB per lane.
- R6: In signed clamping mode with 8- or 16-bit lanes, an exact result above 2^(n-1)-1 gives 2^(n-1)-1, and one below -2^(n-1) gives -2^(n-1). Examples: 16-bit 7000h+2000h gives 7FFFh, and 9000h+9000h gives 8000h.
- R7: In unsigned clamping mode with addition, a lane whose exact sum exceeds 2^n-1 gives 2^n-1. Example: 16-bit F000h+F000h gives FFFFh.
- R8: In unsigned clamping mode with subtraction, a lane whose exact difference is below 0 gives 0.
- R9: With 32- or 64-bit lanes, both clamping modes give the wrap-around result.
- R10: Each lane clamps or wraps independently of the other lanes in the same vector.
- R11: A clamped value fed back as an operand behaves as an ordinary number. Example: 16-bit 7FFFh-0001h gives 7FFEh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 64 | First operand vector (minuend for subtraction) |
| opB | input | 64 | Second operand vector (subtrahend for subtraction) |
| elemSize | input | 2 | Lane width select |
| isSub | input | 1 | 0 = add, 1 = subtract |
| satMode | input | 2 | Arithmetic behaviour select |
| result | output | 64 | Registered result vector |

## Verification
The main function is tried with several kinds of input.

- **Worked 16-bit additions.** Each vector mixes the worked examples in different lanes and is run in signed, unsigned and wrap modes. This shows that the per-lane clamp direction is taken from the lane's own sign and carry.
- **Byte vectors.** These place sign-boundary values such as 7Fh, 80h and C0h next to benign lanes. They separate signed overflow from unsigned overflow and borrow, and they catch a lane whose clamp leaks into its neighbour.
- **Wide-lane cases.** Carries run into the 32-bit and 64-bit boundaries, once with a clamping mode selected. This tells carry isolation apart from a full-width add and shows that clamping is switched off for wide lanes.
- **Pseudo-random sweep.** A sweep over all sizes, modes and directions is compared against an arithmetic model of exact results and limits.

// File: rtl/paddsub_pkg.sv
package paddsub_pkg;

  localparam int NUM_BYTES = 8;
  localparam int BYTE_W    = 8;
  localparam int DATA_W    = NUM_BYTES * BYTE_W;

  typedef enum logic [1:0] {
    ELEM_BYTE  = 2'b00,
    ELEM_WORD  = 2'b01,
    ELEM_DWORD = 2'b10,
    ELEM_QWORD = 2'b11
  } elemSize_e;

  typedef enum logic [1:0] {
    MODE_WRAP     = 2'b00,
    MODE_SSAT     = 2'b01,
    MODE_USAT     = 2'b10,
    MODE_WRAP_ALT = 2'b11
  } satMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_BYTES-1:0] laneStart;     // byte begins a lane: carry-in forced
    logic                 invertB;       // subtract: complement B, carry-in one
    logic                 clampSigned;   // signed limit active
    logic                 clampUnsigned; // unsigned limit active
    logic                 wordLanes;     // lanes are byte pairs
  } strobes_t;

endpackage

// File: rtl/paddsub_ctrl.sv
module paddsub_ctrl
  import paddsub_pkg::*;
(
  input  logic [1:0] elemSize,
  input  logic       isSub,
  input  logic [1:0] satMode,
  output strobes_t   strobes
);

  logic clampAllowed;
  int unsigned span;

  // Clamping exists only for byte and word lanes
  assign clampAllowed = (elemSize == ELEM_BYTE) || (elemSize == ELEM_WORD);

  always_comb begin
    span = 32'd1 << elemSize;
    strobes = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      strobes.laneStart[i] = ((i % span) == 0);
    end
    strobes.invertB       = isSub;
    strobes.clampSigned   = clampAllowed && (satMode == MODE_SSAT);
    strobes.clampUnsigned = clampAllowed && (satMode == MODE_USAT);
    strobes.wordLanes     = (elemSize == ELEM_WORD);
  end

endmodule

// File: rtl/paddsub_datapath.sv
module paddsub_datapath
  import paddsub_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  strobes_t          strobes,
  output logic [DATA_W-1:0] laneOut
);

  logic [NUM_BYTES-1:0] carryOut;
  logic [NUM_BYTES-1:0] aMsb;
  logic [NUM_BYTES-1:0] bMsb;
  logic [NUM_BYTES-1:0] sMsb;
  logic [NUM_BYTES-1:0] ovSigned;
  logic [NUM_BYTES-1:0] ovUnsigned;
  logic [BYTE_W-1:0]    sumByte [NUM_BYTES];

  // Byte slices of the adder; carries cut where a lane starts
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_slice
    logic [BYTE_W-1:0] aB;
    logic [BYTE_W-1:0] bEff;
    logic              cin;
    logic [BYTE_W:0]   sum9;

    assign aB   = opA[i*BYTE_W +: BYTE_W];
    assign bEff = opB[i*BYTE_W +: BYTE_W] ^ {BYTE_W{strobes.invertB}};

    if (i == 0) begin : g_first
      assign cin = strobes.invertB;
    end else begin : g_rest
      assign cin = strobes.laneStart[i] ? strobes.invertB : carryOut[i-1];
    end

    assign sum9        = {1'b0, aB} + {1'b0, bEff} + {{BYTE_W{1'b0}}, cin};
    assign sumByte[i]  = sum9[BYTE_W-1:0];
    assign carryOut[i] = sum9[BYTE_W];
    assign aMsb[i]     = aB[BYTE_W-1];
    assign bMsb[i]     = bEff[BYTE_W-1];
    assign sMsb[i]     = sum9[BYTE_W-1];

    // Meaningful where this byte is the top of its lane
    assign ovSigned[i]   = (aMsb[i] == bMsb[i]) && (sMsb[i] != aMsb[i]);
    assign ovUnsigned[i] = (carryOut[i] != strobes.invertB);
  end

  // Per-byte result selection from the lane's top-byte decisions
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_clamp
    localparam int PAIR_TOP = i | 1;
    localparam bit ODD_BYTE = (i % 2) == 1;

    logic              laneOvS;
    logic              laneOvU;
    logic              laneNeg;
    logic              isTop;
    logic [BYTE_W-1:0] clampS;
    logic [BYTE_W-1:0] clampU;

    assign laneOvS = strobes.wordLanes ? ovSigned[PAIR_TOP]   : ovSigned[i];
    assign laneOvU = strobes.wordLanes ? ovUnsigned[PAIR_TOP] : ovUnsigned[i];
    assign laneNeg = strobes.wordLanes ? aMsb[PAIR_TOP]       : aMsb[i];
    assign isTop   = strobes.wordLanes ? ODD_BYTE : 1'b1;

    // Signed limit: overflow direction follows operand A's sign
    assign clampS = isTop ? {laneNeg, {(BYTE_W-1){~laneNeg}}}
                          : {BYTE_W{~laneNeg}};
    // Unsigned limit: all ones on carry-out of add, zero on borrow
    assign clampU = {BYTE_W{~strobes.invertB}};

    always_comb begin
      if (strobes.clampSigned && laneOvS) begin
        laneOut[i*BYTE_W +: BYTE_W] = clampS;
      end else if (strobes.clampUnsigned && laneOvU) begin
        laneOut[i*BYTE_W +: BYTE_W] = clampU;
      end else begin
        laneOut[i*BYTE_W +: BYTE_W] = sumByte[i];
      end
    end
  end

endmodule

// File: rtl/packed_sat_addsub.sv
module packed_sat_addsub
  import paddsub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        elemSize,
  input  logic              isSub,
  input  logic [1:0]        satMode,
  output logic [DATA_W-1:0] result
);

  strobes_t          strobes;
  logic [DATA_W-1:0] laneOut;

  paddsub_ctrl u_ctrl (
    .elemSize (elemSize),
    .isSub    (isSub),
    .satMode  (satMode),
    .strobes  (strobes)
  );

  paddsub_datapath u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .laneOut  (laneOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else begin
      result <= laneOut;
    end
  end

  // Byte lane 0 in wrap mode equals the modular sum
  AST_WRAP_LANE0_MODULAR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(satMode == MODE_WRAP) && $past(elemSize == ELEM_BYTE)
     && $past(!isSub)) |-> (result[7:0] == $past(opA[7:0] + opB[7:0]))); // R3

  // Signed clamped byte add of like-signed operands keeps that sign
  AST_SSAT_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(satMode == MODE_SSAT) && $past(elemSize == ELEM_BYTE)
     && $past(!isSub) && $past(opA[7] == opB[7])) |-> (result[7] == $past(opA[7]))); // R6

  // Unsigned clamped byte add never drops below operand A
  AST_USAT_ADD_NOT_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(satMode == MODE_USAT) && $past(elemSize == ELEM_BYTE)
     && $past(!isSub)) |-> (result[7:0] >= $past(opA[7:0]))); // R7

  // Unsigned clamped byte subtract never rises above operand A
  AST_USAT_SUB_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(satMode == MODE_USAT) && $past(elemSize == ELEM_BYTE)
     && $past(isSub)) |-> (result[7:0] <= $past(opA[7:0]))); // R8

endmodule

// File: tb/tb_packed_sat_addsub.sv
`timescale 1ns/100ps
module tb_packed_sat_addsub;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [1:0]  elemSize = '0;
  logic        isSub = 1'b0;
  logic [1:0]  satMode = '0;
  logic [63:0] result;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  packed_sat_addsub dut (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .elemSize (elemSize),
    .isSub    (isSub),
    .satMode  (satMode),
    .result   (result)
  );

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  size;
    logic        sub;
    logic [1:0]  mode;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{64'h7000_F000_9000_7FFF, 64'h2000_F000_9000_FF00, 2'd1, 1'b0, 2'd1, 64'h7FFF_E000_8000_7EFF, 8'd6},  // R6
    '{64'h7000_F000_9000_7FFF, 64'h2000_F000_9000_FF00, 2'd1, 1'b0, 2'd2, 64'h9000_FFFF_FFFF_FFFF, 8'd7},  // R7
    '{64'h7FFF_7000_0000_8000, 64'h0100_7000_0000_FFFF, 2'd1, 1'b0, 2'd1, 64'h7FFF_7FFF_0000_8000, 8'd6},  // R6
    '{64'h7FFF_7000_0000_8000, 64'h0100_7000_0000_FFFF, 2'd1, 1'b0, 2'd2, 64'h80FF_E000_0000_FFFF, 8'd7},  // R7
    '{64'h7FFF_7000_0000_8000, 64'h0100_7000_0000_FFFF, 2'd1, 1'b0, 2'd0, 64'h80FF_E000_0000_7FFF, 8'd4},  // R4
    '{64'h7FFF_8000_0005_7FFF, 64'h0001_0001_FFFF_8000, 2'd1, 1'b1, 2'd1, 64'h7FFE_8000_0006_7FFF, 8'd6},  // R6
    '{64'h7FFF_8000_0005_7FFF, 64'h0001_0001_FFFF_8000, 2'd1, 1'b1, 2'd2, 64'h7FFE_7FFF_0000_0000, 8'd8},  // R8
    '{64'h7F80_01FF_40C0_007F, 64'h01FF_01FF_40C0_0080, 2'd0, 1'b0, 2'd1, 64'h7F80_02FE_7F80_00FF, 8'd10}, // R10
    '{64'h7F80_01FF_40C0_007F, 64'h01FF_01FF_40C0_0080, 2'd0, 1'b0, 2'd2, 64'h80FF_02FF_80FF_00FF, 8'd10}, // R10
    '{64'h7F80_01FF_40C0_007F, 64'h01FF_01FF_40C0_0080, 2'd0, 1'b0, 2'd0, 64'h807F_02FE_8080_00FF, 8'd3},  // R3
    '{64'h0010_FF80_017F_2005, 64'h0110_0081_0080_1F06, 2'd0, 1'b1, 2'd2, 64'h0000_FF00_0100_0100, 8'd8},  // R8
    '{64'h0010_FF80_017F_2005, 64'h0110_0081_0080_1F06, 2'd0, 1'b1, 2'd1, 64'hFF00_FFFF_017F_01FF, 8'd5},  // R5
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 1'b0, 2'd0, 64'h8000_0000_0000_0000, 8'd3},  // R3
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd3, 1'b0, 2'd0, 64'h8000_0001_0000_0000, 8'd3},  // R3
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 1'b0, 2'd1, 64'h8000_0000_0000_0000, 8'd9},  // R9
    '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'd3, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'd9},  // R9
    '{64'h7000_7000_7000_7000, 64'h7000_7000_7000_7000, 2'd1, 1'b0, 2'd3, 64'hE000_E000_E000_E000, 8'd4},  // R4
    '{64'h0000_0000_0000_0000, 64'h0001_0000_0000_0000, 2'd1, 1'b1, 2'd0, 64'hFFFF_0000_0000_0000, 8'd5},  // R5
    '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0100, 2'd0, 1'b1, 2'd0, 64'h0000_0000_0000_FF00, 8'd3}   // R3
  };

  task automatic check(input int req, input logic [63:0] got, input logic [63:0] exp,
                       input string what);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                       input logic sb, input logic [1:0] md);
    @(negedge clk);
    opA = a; opB = b; elemSize = sz; isSub = sb; satMode = md;
    @(negedge clk);
  endtask

  // Arithmetic model: exact lane result, then limits or modulo
  function automatic logic [63:0] refModel(input logic [63:0] a, input logic [63:0] b,
                                           input logic [1:0] sz, input logic sb,
                                           input logic [1:0] md);
    logic [63:0] r;
    logic [63:0] mask;
    logic signed [66:0] ua, ub, sa, sbv, ex, one, lo, hi;
    int n;
    n = 8 << sz;
    r = '0;
    one = 67'sd1;
    mask = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    for (int l = 0; l < 64 / n; l++) begin
      ua = $signed({3'b000, (a >> (l * n)) & mask});
      ub = $signed({3'b000, (b >> (l * n)) & mask});
      sa = ua[n-1] ? ua - (one <<< n) : ua;
      sbv = ub[n-1] ? ub - (one <<< n) : ub;
      if (md == 2'd1 && n <= 16) begin
        ex = sb ? sa - sbv : sa + sbv;
        hi = (one <<< (n - 1)) - one;
        lo = -(one <<< (n - 1));
        if (ex > hi) ex = hi;
        if (ex < lo) ex = lo;
      end else if (md == 2'd2 && n <= 16) begin
        ex = sb ? ua - ub : ua + ub;
        hi = (one <<< n) - one;
        if (ex > hi) ex = hi;
        if (ex < 0) ex = 0;
      end else begin
        ex = sb ? ua - ub : ua + ub;
      end
      r = r | ((ex[63:0] & mask) << (l * n));
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] lfsr;
    logic [63:0] held;

    // R1: reset holds the output at zero even with operands present
    opA = 64'h7000_7000_7000_7000; opB = 64'h7000_7000_7000_7000;
    repeat (3) @(negedge clk);
    check(1, result, 64'h0, "result under reset");
    rstN = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].size, VECS[i].sub, VECS[i].mode);
      check(int'(VECS[i].req), result, VECS[i].exp, $sformatf("table vector %0d", i));
    end

    // R2: output holds until the next rising edge, then updates
    apply(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'd3, 1'b0, 2'd0);
    held = result;
    opA = 64'h0000_0000_0000_0010;
    #1;
    check(2, result, held, "value before edge");
    @(negedge clk);
    check(2, result, 64'h0000_0000_0000_0011, "value after edge");

    // R11: clamped value fed back behaves normally
    apply(64'h0000_0000_0000_7FFF, 64'h0000_0000_0000_0100, 2'd1, 1'b0, 2'd1);
    check(6, result, 64'h0000_0000_0000_7FFF, "clamp before reuse");
    apply(result, 64'h0000_0000_0000_0001, 2'd1, 1'b1, 2'd1);
    check(11, result, 64'h0000_0000_0000_7FFE, "clamped value reused");

    // R10: pseudo-random sweep against the model
    lfsr = 64'hACE1_2468_1357_BDF0;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      logic [63:0] b;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      a = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      b = lfsr;
      apply(a, b, 2'(i % 4), 1'((i / 4) % 2), 2'((i / 8) % 4));
      check(10, result, refModel(a, b, 2'(i % 4), 1'((i / 4) % 2), 2'((i / 8) % 4)),
            $sformatf("sweep %0d", i));
    end

    // R1: reasserted reset clears a nonzero result
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(1, result, 64'h0, "reset reasserted");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule